// File: doc/BRIEF.md
# Fuse Block Map Engine

This engine keeps the table that ties logical 16-byte blocks of a one-time-programmable fuse array to the physical fuse blocks that hold them. The table lives in the top blocks of the fuse array. It has one byte per physical block, and a byte's index from the start of the table is the physical block number. A used byte carries logical address bits 9:4 in its low six bits. Its top two bits are inverted-XOR parity bits. A zero byte is unused. A byte whose parity no longer checks is dead.

A controller issues one command at a time. Lookup finds the physical block that holds a logical block. Allocate claims the first unused byte and programs an encoded entry into it. Invalidate kills an entry. Count reports how many entries remain unused. The engine reaches the fuse array only through a 16-bit word port with single-cycle read latency. It reads each table word once and looks at both of its bytes in the same cycle. Copying and checking the block data stays with the controller, which uses the results this engine returns.

Top module: `fuse_blkmap_engine`

## Requirements
- R1: After reset, busy, done, mem_req and mem_we are all low.
- R2: The table occupies byte addresses 0x2D0 to 0x2FC. Table word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8, and mem_addr is the word index (byte address divided by two). The engine never addresses a word outside the table.
- R3: An encoded entry for logical block a (address bits 9:4) is the byte {~(a5^a4^a3^a2), ~(a3^a2^a1^a0), a[5:0]}. An entry is valid only when it equals the encoding of its own low six bits.
- R4: Allocate (cmd_op 1) chooses the first zero byte in ascending byte order, so within a word the low byte comes before the high byte. It returns that byte's address minus 0x2D0. It writes the encoded entry into that byte and leaves the other byte of the word unchanged.
- R5: Byte 0x2FD, the high byte of the last table word, is never allocated and never matched. When no other byte is zero, allocate returns 0xFFFF and writes nothing.
- R6: Lookup (cmd_op 0) returns the block number of the first valid entry whose low six bits equal cmd_lblk. Entries with bad parity are skipped. When no entry matches, it returns 0x003F. Lookup never writes.
- R7: Invalidate (cmd_op 2) of block b sets the lowest zero bit of byte 0x2D0+b, writes it back and returns the new byte (zero-extended). A byte of 0xFF is left unwritten and returns 0x00FF. A block number above 44 returns 0xFFFF with no memory access.
- R8: Count (cmd_op 3) finds the first zero byte at word byte address i. It returns 0x2FC-i+1 when that byte is the low byte and 0x2FC-i when it is the high byte. It returns 0 when no byte is zero, and it never writes.
- R9: A command is taken only while busy is low. A cmd_valid that arrives while busy is high is ignored. done is a single-cycle pulse that marks result valid, and busy falls on the cycle after done.
- R10: mem_we is only asserted together with mem_req. Each command writes at most one word, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 lookup, 1 allocate, 2 invalidate, 3 count |
| cmd_lblk | input | 6 | Logical block number (address bits 9:4) |
| cmd_blk | input | 6 | Physical block number for invalidate |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 16 | Block number, count, entry byte or sentinel |
| mem_req | output | 1 | Fuse word access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 9 | Fuse word index |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |

## Verification
A wrong scan pointer or a wrong lane choice shows up in the result as soon as done pulses: a shifted block number, a count that is off by one, or a byte landing in the wrong half of a word in the fuse model. The bench fills the table one entry at a time and looks up and counts after each step. Because every command finishes within about fifty cycles, a corrupted entry or a stray write appears at the latest on the next command. Parity mistakes show up as lookups that match entries they should skip, and invalidated entries that still resolve.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    localparam int KEY_W = 6;

    localparam logic [15:0] NO_SPACE = 16'hFFFF;
    localparam logic [15:0] NO_MATCH = 16'h003F;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ALLOC  = 2'd1,
        OP_INVAL  = 2'd2,
        OP_COUNT  = 2'd3
    } fbm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } fbm_state_e;

    typedef struct packed {
        logic free;
        logic hit;
    } lane_flags_t;

    // bit 7 guards address bits 5:2, bit 6 guards address bits 3:0
    function automatic logic [7:0] entry_encode(input logic [KEY_W-1:0] a);
        return {~(a[5] ^ a[4] ^ a[3] ^ a[2]), ~(a[3] ^ a[2] ^ a[1] ^ a[0]), a};
    endfunction

    function automatic logic entry_valid(input logic [7:0] e);
        return e == entry_encode(e[KEY_W-1:0]);
    endfunction

    // sets the lowest clear bit of a byte
    function automatic logic [7:0] kill_entry(input logic [7:0] e);
        return e | (e + 8'd1);
    endfunction

endpackage

// File: rtl/fbm_lane.sv
module fbm_lane
    import fbm_pkg::*;
(
    input  logic [7:0]       entry,
    input  logic             usable,
    input  logic [KEY_W-1:0] key,
    output lane_flags_t      flags
);
    always_comb begin
        flags.free = usable && (entry == 8'h00);
        flags.hit  = usable && entry_valid(entry) && (entry[KEY_W-1:0] == key);
    end
endmodule

// File: rtl/fbm_word_eval.sv
module fbm_word_eval
    import fbm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0]           rdata,
    input  logic                         last_word,
    input  logic [KEY_W-1:0]             key,
    output lane_flags_t [LANES-1:0]      flags
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit FIRST = (g == 0);
        logic lane_ok;
        // only the first byte of the final word belongs to the table
        assign lane_ok = FIRST || !last_word;
        fbm_lane u_lane (
            .entry  (rdata[8*g +: 8]),
            .usable (lane_ok),
            .key    (key),
            .flags  (flags[g])
        );
    end
endmodule

// File: rtl/fbm_seq.sv
module fbm_seq
    import fbm_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MAP_START = 32'h2D0,
    parameter int MAP_END   = 32'h2FC,
    parameter int BLK_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [KEY_W-1:0]      cmd_lblk,
    input  logic [BLK_W-1:0]      cmd_blk,
    output logic                  busy,
    output logic                  done,
    output logic [15:0]           result,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-2:0]     mem_addr,
    output logic [15:0]           mem_wdata,
    input  logic [15:0]           mem_rdata,
    input  lane_flags_t [1:0]     flags,
    output logic                  last_word,
    output logic [KEY_W-1:0]      key
);
    localparam int WA_W    = ADDR_W - 1;
    localparam int MAP_CNT = MAP_END - MAP_START + 1;
    localparam logic [WA_W-1:0] START_W = WA_W'(MAP_START / 2);
    localparam logic [WA_W-1:0] END_W   = WA_W'(MAP_END / 2);

    fbm_state_e      state_q;
    fbm_op_e         op_q;
    logic [KEY_W-1:0] key_q;
    logic            lane_sel_q;
    logic [WA_W-1:0] cur_w_q;
    logic [15:0]     wr_q;
    logic [15:0]     res_q;

    logic [15:0] base16, blk0, blk1, cnt_low, cnt_high;
    logic [7:0]  sel_byte, new_byte;

    always_comb begin
        base16   = 16'({cur_w_q, 1'b0});
        blk0     = base16 - 16'(MAP_START);
        blk1     = blk0 + 16'd1;
        cnt_low  = 16'(MAP_END) - base16 + 16'd1;
        cnt_high = 16'(MAP_END) - base16;
        sel_byte = lane_sel_q ? mem_rdata[15:8] : mem_rdata[7:0];
        new_byte = kill_entry(sel_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_LOOKUP;
            key_q      <= '0;
            lane_sel_q <= 1'b0;
            cur_w_q    <= START_W;
            wr_q       <= '0;
            res_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q       <= fbm_op_e'(cmd_op);
                        key_q      <= cmd_lblk;
                        lane_sel_q <= cmd_blk[0];
                        if (fbm_op_e'(cmd_op) == OP_INVAL) begin
                            if (32'(cmd_blk) >= MAP_CNT) begin
                                res_q   <= NO_SPACE;
                                state_q <= ST_DONE;
                            end else begin
                                cur_w_q <= START_W + WA_W'(cmd_blk >> 1);
                                state_q <= ST_REQ;
                            end
                        end else begin
                            cur_w_q <= START_W;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: state_q <= ST_EVAL;
                ST_EVAL: begin
                    state_q <= ST_DONE;
                    case (op_q)
                        OP_LOOKUP: begin
                            if (flags[0].hit)      res_q <= blk0;
                            else if (flags[1].hit) res_q <= blk1;
                            else if (last_word)    res_q <= NO_MATCH;
                            else begin
                                cur_w_q <= cur_w_q + 1'b1;
                                state_q <= ST_REQ;
                            end
                        end
                        OP_ALLOC: begin
                            if (flags[0].free) begin
                                res_q   <= blk0;
                                wr_q    <= {mem_rdata[15:8], entry_encode(key_q)};
                                state_q <= ST_WRITE;
                            end else if (flags[1].free) begin
                                res_q   <= blk1;
                                wr_q    <= {entry_encode(key_q), mem_rdata[7:0]};
                                state_q <= ST_WRITE;
                            end else if (last_word) begin
                                res_q <= NO_SPACE;
                            end else begin
                                cur_w_q <= cur_w_q + 1'b1;
                                state_q <= ST_REQ;
                            end
                        end
                        OP_COUNT: begin
                            if (flags[0].free)      res_q <= cnt_low;
                            else if (flags[1].free) res_q <= cnt_high;
                            else if (last_word)     res_q <= 16'd0;
                            else begin
                                cur_w_q <= cur_w_q + 1'b1;
                                state_q <= ST_REQ;
                            end
                        end
                        default: begin
                            if (sel_byte == 8'hFF) begin
                                res_q <= 16'h00FF;
                            end else begin
                                res_q   <= {8'h00, new_byte};
                                wr_q    <= lane_sel_q ? {new_byte, mem_rdata[7:0]}
                                                      : {mem_rdata[15:8], new_byte};
                                state_q <= ST_WRITE;
                            end
                        end
                    endcase
                end
                ST_WRITE: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        result    = res_q;
        mem_req   = (state_q == ST_REQ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = cur_w_q;
        mem_wdata = wr_q;
        last_word = (cur_w_q == END_W);
        key       = key_q;
    end
endmodule

// File: rtl/fuse_blkmap_engine.sv
module fuse_blkmap_engine
    import fbm_pkg::*;
#(
    parameter  int ADDR_W    = 10,
    parameter  int MAP_START = 32'h2D0,
    parameter  int MAP_END   = 32'h2FC,
    localparam int BLK_W     = $clog2(MAP_END - MAP_START + 1),
    localparam int WA_W      = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [5:0]        cmd_lblk,
    input  logic [BLK_W-1:0]  cmd_blk,
    output logic              busy,
    output logic              done,
    output logic [15:0]       result,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WA_W-1:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    lane_flags_t [1:0] flags;
    logic              last_word;
    logic [KEY_W-1:0]  key;

    fbm_seq #(
        .ADDR_W    (ADDR_W),
        .MAP_START (MAP_START),
        .MAP_END   (MAP_END),
        .BLK_W     (BLK_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_lblk  (cmd_lblk),
        .cmd_blk   (cmd_blk),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .flags     (flags),
        .last_word (last_word),
        .key       (key)
    );

    fbm_word_eval #(.LANES(2)) u_eval (
        .rdata     (mem_rdata),
        .last_word (last_word),
        .key       (key),
        .flags     (flags)
    );
endmodule

// File: rtl/fbm_checker.sv
module fbm_checker #(
    parameter int WA_W    = 9,
    parameter int START_W = 32'h168,
    parameter int END_W   = 32'h17E
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic            mem_we,
    input logic [WA_W-1:0] mem_addr
);
    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);                                          // R10
    AST_NO_BACK_TO_BACK_WR: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);                                          // R10
    AST_MAP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(mem_addr) >= START_W && 32'(mem_addr) <= END_W)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                              // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);                                          // R9
    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> busy);                               // R9
endmodule

bind fuse_blkmap_engine fbm_checker #(
    .WA_W    (WA_W),
    .START_W (MAP_START / 2),
    .END_W   (MAP_END / 2)
) u_fbm_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/fuse_blkmap_engine_bench.sv
`timescale 1ns/1ps
module fuse_blkmap_engine_bench;
    localparam int START = 32'h2D0;
    localparam int ENDB  = 32'h2FC;
    localparam int CNT   = ENDB - START + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [5:0]  cmd_lblk = 6'd0;
    logic [5:0]  cmd_blk = 6'd0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] result, mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [8:0]  mem_addr;

    logic [15:0] fmem [0:511];
    int wr_cnt = 0;
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fuse_blkmap_engine u_fuse_blkmap_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lblk(cmd_lblk), .cmd_blk(cmd_blk), .busy(busy), .done(done),
        .result(result), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            fmem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end else if (mem_req) begin
            mem_rdata <= fmem[mem_addr];
        end
    end

    function automatic logic [7:0] enc(input logic [5:0] a);
        logic p6, p7;
        p6 = ~^a[3:0];
        p7 = ~^a[5:2];
        return {p7, p6, a};
    endfunction

    function automatic logic [7:0] get_byte(input int b);
        return b[0] ? fmem[b >> 1][15:8] : fmem[b >> 1][7:0];
    endfunction

    task automatic put_byte(input int b, input logic [7:0] v);
        if (b[0]) fmem[b >> 1][15:8] = v;
        else      fmem[b >> 1][7:0]  = v;
    endtask

    task automatic fill_map(input logic [7:0] v);
        for (int b = START; b <= ENDB + 1; b++) put_byte(b, v);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [5:0] lb,
                          input logic [5:0] blk, output logic [15:0] res);
        int g;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_lblk = lb; cmd_blk = blk;
        @(negedge clk);
        cmd_valid = 1'b0;
        g = 0;
        while (!done && g < 1000) begin
            @(negedge clk);
            g++;
        end
        if (!done) begin
            n_err++;
            $display("FAIL R9: done missing, actual 0 expected 1");
        end
        res = result;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int w0;
        logic [7:0] b, eb;
        for (int i = 0; i < 512; i++) fmem[i] = 16'h0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 mem_req", {15'd0, mem_req}, 16'd0);
        chk("R1 mem_we", {15'd0, mem_we}, 16'd0);
        rst = 1'b0;

        // empty table
        do_cmd(2'd3, 6'd0, 6'd0, r); chk("R8 count empty", r, 16'(CNT));
        do_cmd(2'd0, 6'd5, 6'd0, r); chk("R6 lookup empty", r, 16'h003F);

        // fill every entry in order, R3 R4 R8
        for (int k = 0; k < CNT; k++) begin
            w0 = wr_cnt;
            do_cmd(2'd1, 6'(k), 6'd0, r);
            chk("R4 alloc block", r, 16'(k));
            chk("R3 entry byte", {8'd0, get_byte(START + k)}, {8'd0, enc(6'(k))});
            chk("R10 one write", 16'(wr_cnt - w0), 16'd1);
            if (k + 1 < CNT) chk("R2 neighbour byte kept", {8'd0, get_byte(START + k + 1)}, 16'd0);
            do_cmd(2'd3, 6'd0, 6'd0, r); chk("R8 count", r, 16'(CNT - k - 1));
        end
        // full: R5
        w0 = wr_cnt;
        do_cmd(2'd1, 6'd50, 6'd0, r); chk("R5 full alloc", r, 16'hFFFF);
        chk("R5 no write", 16'(wr_cnt - w0), 16'd0);
        chk("R5 reserved byte", {8'd0, get_byte(ENDB + 1)}, 16'd0);

        // lookups R6
        for (int k = 0; k < 64; k++) begin
            do_cmd(2'd0, 6'(k), 6'd0, r);
            chk("R6 lookup", r, (k < CNT) ? 16'(k) : 16'h003F);
        end

        // invalidate even blocks R7
        for (int k = 0; k < CNT; k += 2) begin
            b = get_byte(START + k);
            eb = b | (b + 8'd1);
            do_cmd(2'd2, 6'd0, 6'(k), r);
            chk("R7 invalidate result", r, {8'd0, eb});
            chk("R7 invalidate byte", {8'd0, get_byte(START + k)}, {8'd0, eb});
        end
        for (int k = 0; k < CNT; k++) begin
            do_cmd(2'd0, 6'(k), 6'd0, r);
            chk("R7 lookup after kill", r, (k % 2 == 0) ? 16'h003F : 16'(k));
        end

        // R7 boundaries
        put_byte(START + 10, 8'hFF);
        w0 = wr_cnt;
        do_cmd(2'd2, 6'd0, 6'd10, r); chk("R7 all ones", r, 16'h00FF);
        do_cmd(2'd2, 6'd0, 6'd45, r); chk("R7 out of range", r, 16'hFFFF);
        do_cmd(2'd2, 6'd0, 6'd63, r); chk("R7 out of range hi", r, 16'hFFFF);
        chk("R7 no write", 16'(wr_cnt - w0), 16'd0);

        // R5 reserved byte not usable, R8 count zero
        fill_map(8'hFF);
        put_byte(ENDB + 1, 8'h00);
        w0 = wr_cnt;
        do_cmd(2'd1, 6'd9, 6'd0, r); chk("R5 reserved not allocated", r, 16'hFFFF);
        do_cmd(2'd3, 6'd0, 6'd0, r); chk("R8 count none", r, 16'd0);
        chk("R5 no write", 16'(wr_cnt - w0), 16'd0);
        put_byte(ENDB + 1, enc(6'd7));
        do_cmd(2'd0, 6'd7, 6'd0, r); chk("R5 reserved not matched", r, 16'h003F);

        // high byte free first, R4 R8
        put_byte(START + 7, 8'h00);
        put_byte(START + 20, 8'h00);
        do_cmd(2'd3, 6'd0, 6'd0, r); chk("R8 count high", r, 16'(ENDB - (START + 6)));
        do_cmd(2'd1, 6'd9, 6'd0, r); chk("R4 alloc high", r, 16'd7);
        chk("R4 word merge", fmem[(START + 6) >> 1], {enc(6'd9), 8'hFF});
        do_cmd(2'd3, 6'd0, 6'd0, r); chk("R8 count low", r, 16'(ENDB - (START + 20) + 1));

        // R6 priority and parity skip
        fill_map(8'h00);
        put_byte(START + 3, enc(6'd5) ^ 8'h40);
        put_byte(START + 9, enc(6'd5));
        put_byte(START + 12, enc(6'd5));
        do_cmd(2'd0, 6'd5, 6'd0, r); chk("R6 first valid", r, 16'd9);
        put_byte(START + 9, 8'h00);
        do_cmd(2'd0, 6'd5, 6'd0, r); chk("R6 next valid", r, 16'd12);
        put_byte(START + 3, enc(6'd5) ^ 8'h80);
        put_byte(START + 12, 8'h00);
        do_cmd(2'd0, 6'd5, 6'd0, r); chk("R6 bad parity", r, 16'h003F);

        // R9 command while busy is ignored
        w0 = wr_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_lblk = 6'd60;
        @(negedge clk);
        cmd_op = 2'd1; cmd_lblk = 6'd2;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int g = 0;
            while (!done && g < 1000) begin @(negedge clk); g++; end
        end
        chk("R9 first command result", result, 16'h003F);
        @(negedge clk);
        chk("R9 busy falls", {15'd0, busy}, 16'd0);
        repeat (10) @(negedge clk);
        chk("R9 ignored no write", 16'(wr_cnt - w0), 16'd0);
        chk("R9 stays idle", {15'd0, busy}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule